// File: doc/BRIEF.md
# Masked Internal Control Register File

This block holds the 64-bit internal control registers of a processor core behind one index. Each index carries its own access class and write mask: ordinary scratch registers accept every bit, configuration registers keep only their defined fields, two exception registers are cleared by any write, two status registers can only be read, and a group of control indices can only be written. A write to one of the control indices stores nothing and emits a single-cycle strobe to the cache and translation logic that consumes it.

One index is a composite cycle register: software writes it as a full 64-bit word, but a read returns the stored upper half joined to the low 32 bits of a free-running cycle counter supplied from outside. The two exception registers also collect hardware event bits from input vectors, and the two read-only indices reflect live status inputs. Any access that the access class forbids, or any access to an index that has no register, is refused. The refused access raises a one-cycle error pulse and changes nothing.

Read data, the error pulse and the strobes are all registered, so each appears in the cycle after the access is presented. The reset values, the code base address and the core identifier, are parameters.

Top module: `icr_file`

## Requirements
- R1: After reset every register reads zero, except mode control (index 9), which reads 0x6, code base (index 8), which reads the CODE_BASE_RST parameter, and scratch slot ID_SLOT (one of indices 0 to 7), which reads CORE_ID.
- R2: Scratch indices 0 to 7, code base (8) and mode control (9) store all 64 written bits. A read presented in the cycle after a write returns the new value.
- R3: A read of the cycle register (index 24) returns the stored bits 63:32 in its upper half and the value of cyc_cnt_i in the access cycle in its lower half. A write to index 24 stores all 64 bits.
- R4: The trap request and trap enable registers (10, 11) keep only write bits 3:0. The current and alternate mode registers (12, 13) keep only bits 4:3 (mask 0x18).
- R5: The remaining write masks are as follows. Interrupt control (16) uses 0xFF_FFFF_0300. Both page-table base registers (17, 18) keep bits 63:30. Cache test (19) uses 0x1FFB. Cache mode (20) and miss mode (21) use 0x3F. Instruction address-space id (22) uses 0x7F0. Data address-space id (23) keeps bits 63:57.
- R6: Any write to exception summary (14) or exception mask (15) clears it, whatever the data. Each of these registers ORs in its event input (exc_sum_set_i, exc_msk_set_i) on every clock, and the event bits are kept even in a cycle that clears the register.
- R7: Indices 25 (interrupt id) and 26 (memory status) are read-only. Reading them returns int_id_i or mm_stat_i. Writing them is illegal.
- R8: Indices 27 to 31 are write-only. Reading them is illegal.
- R9: Indices 32 to 63 are undefined. Reading or writing them is illegal.
- R10: An illegal access, whether a read or a write, raises err_o for exactly the following cycle. It changes no stored register and emits no strobe. If rd_en_i was high, rd_data_o becomes zero. When read and write are presented together, either one being illegal blocks both.
- R11: A legal write to index 27+s pulses strobe_o[s] for one cycle and stores no data. The strobes are ordered as follows: bit 0 instruction cache flush, bit 1 data cache flush, bit 2 instruction translation flush, bit 3 data translation flush, bit 4 interrupt clear.
- R12: rd_data_o, err_o and strobe_o are registered and change one cycle after the access. rd_data_o holds while rd_en_i is low. A read and a write to the same index in the same cycle return the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| idx_i | input | 6 | Register index for the access |
| wr_en_i | input | 1 | Write request |
| wr_data_i | input | 64 | Write data |
| rd_en_i | input | 1 | Read request |
| cyc_cnt_i | input | 32 | Low half of the free-running cycle counter |
| exc_sum_set_i | input | 64 | Event bits ORed into exception summary |
| exc_msk_set_i | input | 64 | Event bits ORed into exception mask |
| int_id_i | input | 64 | Live value of the interrupt id register |
| mm_stat_i | input | 64 | Live value of the memory status register |
| rd_data_o | output | 64 | Registered read data |
| strobe_o | output | 5 | One-cycle side-effect strobes for the write-only indices |
| err_o | output | 1 | One-cycle illegal-access pulse |

## Verification
The hardest case to reach is the interaction between the write-to-clear registers and their event inputs: the registers can only become non-zero through the event vectors, and the clear must lose to events that arrive in the same cycle. The stimulus first raises event bits for a single cycle and reads the bits back. It then issues a clearing write while new event bits are held on the input. The other hard cases are combined read/write cycles, in which one illegal half must block the other half. The stimulus drives both halves together with every pairing of legal and illegal classes, and then finishes with a long run of random indices, data and counter values, checked against the behavioural model.

// File: rtl/icr_pkg.sv
package icr_pkg;

    localparam int DATA_W      = 64;
    localparam int HALF_W      = DATA_W / 2;
    localparam int IDX_W       = 6;
    localparam int NUM_SCRATCH = 8;

    localparam int IX_CODE_BASE = NUM_SCRATCH;
    localparam int IX_MODE_CTL  = NUM_SCRATCH + 1;
    localparam int IX_TRAP_REQ  = NUM_SCRATCH + 2;
    localparam int IX_TRAP_EN   = NUM_SCRATCH + 3;
    localparam int IX_MODE_CUR  = NUM_SCRATCH + 4;
    localparam int IX_MODE_ALT  = NUM_SCRATCH + 5;
    localparam int IX_EXC_SUM   = NUM_SCRATCH + 6;
    localparam int IX_EXC_MSK   = NUM_SCRATCH + 7;
    localparam int IX_INT_CTL   = NUM_SCRATCH + 8;
    localparam int IX_IPT_BASE  = NUM_SCRATCH + 9;
    localparam int IX_DPT_BASE  = NUM_SCRATCH + 10;
    localparam int IX_CTEST     = NUM_SCRATCH + 11;
    localparam int IX_CMODE     = NUM_SCRATCH + 12;
    localparam int IX_MISS_MODE = NUM_SCRATCH + 13;
    localparam int IX_I_ASID    = NUM_SCRATCH + 14;
    localparam int IX_D_ASID    = NUM_SCRATCH + 15;
    localparam int IX_CYCLE     = NUM_SCRATCH + 16;
    localparam int NUM_STORED   = IX_CYCLE + 1;
    localparam int IX_INT_ID    = NUM_STORED;
    localparam int IX_MM_STAT   = NUM_STORED + 1;
    localparam int IX_WO_FIRST  = NUM_STORED + 2;
    localparam int NUM_STROBE   = 5;
    localparam int IX_LAST_DEF  = IX_WO_FIRST + NUM_STROBE - 1;

    localparam logic [DATA_W-1:0] MODE_CTL_RST = 64'h6;

    typedef enum logic [2:0] {
        AC_RW,
        AC_RO,
        AC_WO,
        AC_WCLR,
        AC_NONE
    } acc_cls_e;

    typedef struct packed {
        acc_cls_e          cls;
        logic [DATA_W-1:0] mask;
    } reg_attr_t;

    function automatic reg_attr_t attr_of(input logic [IDX_W-1:0] idx);
        reg_attr_t a;
        int        i;
        i      = int'(idx);
        a.cls  = AC_NONE;
        a.mask = '0;
        if (i < NUM_SCRATCH) begin
            a.cls  = AC_RW;
            a.mask = '1;
        end else if (i >= IX_WO_FIRST && i <= IX_LAST_DEF) begin
            a.cls = AC_WO;
        end else begin
            case (i)
                IX_CODE_BASE, IX_MODE_CTL, IX_CYCLE: begin
                    a.cls = AC_RW; a.mask = '1;
                end
                IX_TRAP_REQ, IX_TRAP_EN: begin
                    a.cls = AC_RW; a.mask = 64'hF;
                end
                IX_MODE_CUR, IX_MODE_ALT: begin
                    a.cls = AC_RW; a.mask = 64'h18;
                end
                IX_EXC_SUM, IX_EXC_MSK: a.cls = AC_WCLR;
                IX_INT_CTL: begin
                    a.cls = AC_RW; a.mask = 64'hFF_FFFF_0300;
                end
                IX_IPT_BASE, IX_DPT_BASE: begin
                    a.cls = AC_RW; a.mask = {{(DATA_W-30){1'b1}}, 30'b0};
                end
                IX_CTEST: begin
                    a.cls = AC_RW; a.mask = 64'h1FFB;
                end
                IX_CMODE, IX_MISS_MODE: begin
                    a.cls = AC_RW; a.mask = 64'h3F;
                end
                IX_I_ASID: begin
                    a.cls = AC_RW; a.mask = 64'h7F0;
                end
                IX_D_ASID: begin
                    a.cls = AC_RW; a.mask = {7'h7F, {(DATA_W-7){1'b0}}};
                end
                IX_INT_ID, IX_MM_STAT: a.cls = AC_RO;
                default: a.cls = AC_NONE;
            endcase
        end
        return a;
    endfunction

    function automatic logic [DATA_W-1:0] reset_value(
        input int                k,
        input logic [DATA_W-1:0] base,
        input logic [DATA_W-1:0] core_id,
        input int                id_slot
    );
        if (k == IX_CODE_BASE) return base;
        if (k == IX_MODE_CTL)  return MODE_CTL_RST;
        if (k == id_slot)      return core_id;
        return '0;
    endfunction

    function automatic logic [DATA_W-1:0] merge_cycle(
        input logic [DATA_W-1:0] stored,
        input logic [HALF_W-1:0] live
    );
        return {stored[DATA_W-1:HALF_W], live};
    endfunction

endpackage

// File: rtl/icr_decode.sv
module icr_decode
    import icr_pkg::*;
(
    input  logic [IDX_W-1:0]      idx_i,
    output reg_attr_t             attr_o,
    output logic [NUM_STROBE-1:0] wo_sel_o
);
    assign attr_o = attr_of(idx_i);

    for (genvar s = 0; s < NUM_STROBE; s++) begin : g_sel
        assign wo_sel_o[s] = (idx_i == IDX_W'(IX_WO_FIRST + s));
    end
endmodule

// File: rtl/icr_store.sv
module icr_store
    import icr_pkg::*;
#(
    parameter logic [DATA_W-1:0] CODE_BASE_RST = 64'h0000_0000_0002_0000,
    parameter logic [DATA_W-1:0] CORE_ID       = 64'h3,
    parameter int                ID_SLOT       = 6
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic                                 wr_ok_i,
    input  logic [IDX_W-1:0]                     idx_i,
    input  logic [DATA_W-1:0]                    wr_data_i,
    input  reg_attr_t                            attr_i,
    input  logic [DATA_W-1:0]                    sum_set_i,
    input  logic [DATA_W-1:0]                    msk_set_i,
    output logic [NUM_STORED-1:0][DATA_W-1:0]    regs_o
);
    logic [DATA_W-1:0] wr_val;
    assign wr_val = (attr_i.cls == AC_WCLR) ? '0 : (wr_data_i & attr_i.mask);

    for (genvar k = 0; k < NUM_STORED; k++) begin : g_reg
        logic              hit;
        logic [DATA_W-1:0] setb;
        logic [DATA_W-1:0] q;

        assign hit = wr_ok_i && (idx_i == IDX_W'(k));

        if (k == IX_EXC_SUM) begin : g_sum
            assign setb = sum_set_i;
        end else if (k == IX_EXC_MSK) begin : g_msk
            assign setb = msk_set_i;
        end else begin : g_none
            assign setb = '0;
        end

        always_ff @(posedge clk) begin
            if (rst)      q <= reset_value(k, CODE_BASE_RST, CORE_ID, ID_SLOT);
            else if (hit) q <= wr_val | setb;
            else          q <= q | setb;
        end

        assign regs_o[k] = q;
    end
endmodule

// File: rtl/icr_readport.sv
module icr_readport
    import icr_pkg::*;
(
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              rd_en_i,
    input  logic                              refuse_i,
    input  logic [IDX_W-1:0]                  idx_i,
    input  logic [NUM_STORED-1:0][DATA_W-1:0] regs_i,
    input  logic [HALF_W-1:0]                 cyc_cnt_i,
    input  logic [DATA_W-1:0]                 int_id_i,
    input  logic [DATA_W-1:0]                 mm_stat_i,
    output logic [DATA_W-1:0]                 rd_data_o
);
    logic [DATA_W-1:0] sel;

    always_comb begin
        sel = '0;
        for (int k = 0; k < NUM_STORED; k++) begin
            if (idx_i == IDX_W'(k)) sel = regs_i[k];
        end
        if (idx_i == IDX_W'(IX_CYCLE))   sel = merge_cycle(regs_i[IX_CYCLE], cyc_cnt_i);
        if (idx_i == IDX_W'(IX_INT_ID))  sel = int_id_i;
        if (idx_i == IDX_W'(IX_MM_STAT)) sel = mm_stat_i;
    end

    always_ff @(posedge clk) begin
        if (rst)          rd_data_o <= '0;
        else if (rd_en_i) rd_data_o <= refuse_i ? '0 : sel;
    end
endmodule

// File: rtl/icr_file.sv
module icr_file
    import icr_pkg::*;
#(
    parameter logic [DATA_W-1:0] CODE_BASE_RST = 64'h0000_0000_0002_0000,
    parameter logic [DATA_W-1:0] CORE_ID       = 64'h3,
    parameter int                ID_SLOT       = 6
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [IDX_W-1:0]      idx_i,
    input  logic                  wr_en_i,
    input  logic [DATA_W-1:0]     wr_data_i,
    input  logic                  rd_en_i,
    input  logic [HALF_W-1:0]     cyc_cnt_i,
    input  logic [DATA_W-1:0]     exc_sum_set_i,
    input  logic [DATA_W-1:0]     exc_msk_set_i,
    input  logic [DATA_W-1:0]     int_id_i,
    input  logic [DATA_W-1:0]     mm_stat_i,
    output logic [DATA_W-1:0]     rd_data_o,
    output logic [NUM_STROBE-1:0] strobe_o,
    output logic                  err_o
);
    reg_attr_t                         attr;
    logic [NUM_STROBE-1:0]             wo_sel;
    logic [NUM_STORED-1:0][DATA_W-1:0] regs;
    logic                              wr_bad, rd_bad, refuse, wr_ok;

    icr_decode u_dec (
        .idx_i    (idx_i),
        .attr_o   (attr),
        .wo_sel_o (wo_sel)
    );

    assign wr_bad = (attr.cls == AC_RO) || (attr.cls == AC_NONE);
    assign rd_bad = (attr.cls == AC_WO) || (attr.cls == AC_NONE);
    assign refuse = (wr_en_i && wr_bad) || (rd_en_i && rd_bad);
    assign wr_ok  = wr_en_i && !refuse;

    icr_store #(
        .CODE_BASE_RST (CODE_BASE_RST),
        .CORE_ID       (CORE_ID),
        .ID_SLOT       (ID_SLOT)
    ) u_store (
        .clk       (clk),
        .rst       (rst),
        .wr_ok_i   (wr_ok),
        .idx_i     (idx_i),
        .wr_data_i (wr_data_i),
        .attr_i    (attr),
        .sum_set_i (exc_sum_set_i),
        .msk_set_i (exc_msk_set_i),
        .regs_o    (regs)
    );

    icr_readport u_rd (
        .clk       (clk),
        .rst       (rst),
        .rd_en_i   (rd_en_i),
        .refuse_i  (refuse),
        .idx_i     (idx_i),
        .regs_i    (regs),
        .cyc_cnt_i (cyc_cnt_i),
        .int_id_i  (int_id_i),
        .mm_stat_i (mm_stat_i),
        .rd_data_o (rd_data_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            err_o    <= 1'b0;
            strobe_o <= '0;
        end else begin
            err_o    <= refuse;
            strobe_o <= (wr_ok && attr.cls == AC_WO) ? wo_sel : '0;
        end
    end
endmodule

// File: rtl/icr_file_chk.sv
module icr_file_chk
    import icr_pkg::*;
(
    input logic                  clk,
    input logic                  rst,
    input logic [IDX_W-1:0]      idx_i,
    input logic                  wr_en_i,
    input logic                  rd_en_i,
    input logic [HALF_W-1:0]     cyc_cnt_i,
    input logic [DATA_W-1:0]     rd_data_o,
    input logic [NUM_STROBE-1:0] strobe_o,
    input logic                  err_o
);
    logic undef_ix, ro_ix, wo_ix;
    assign undef_ix = int'(idx_i) > IX_LAST_DEF;
    assign ro_ix    = (int'(idx_i) == IX_INT_ID) || (int'(idx_i) == IX_MM_STAT);
    assign wo_ix    = (int'(idx_i) >= IX_WO_FIRST) && (int'(idx_i) <= IX_LAST_DEF);

    p_undef_err_r9: assert property (@(posedge clk) disable iff (rst)
        ((wr_en_i || rd_en_i) && undef_ix) |=> err_o);

    p_ro_write_err_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && ro_ix) |=> (err_o && strobe_o == '0));

    p_wo_read_err_r8: assert property (@(posedge clk) disable iff (rst)
        (rd_en_i && wo_ix) |=> (err_o && rd_data_o == '0));

    p_strobe_onehot_r11: assert property (@(posedge clk) disable iff (rst)
        $onehot0(strobe_o));

    p_strobe_no_err_r10: assert property (@(posedge clk) disable iff (rst)
        (strobe_o != '0) |-> !err_o);

    p_cycle_low_r3: assert property (@(posedge clk) disable iff (rst)
        (rd_en_i && !wr_en_i && int'(idx_i) == IX_CYCLE)
        |=> (rd_data_o[HALF_W-1:0] == $past(cyc_cnt_i)));

    p_quiet_r12: assert property (@(posedge clk) disable iff (rst)
        (!wr_en_i && !rd_en_i) |=> (!err_o && strobe_o == '0 && $stable(rd_data_o)));
endmodule

bind icr_file icr_file_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .idx_i     (idx_i),
    .wr_en_i   (wr_en_i),
    .rd_en_i   (rd_en_i),
    .cyc_cnt_i (cyc_cnt_i),
    .rd_data_o (rd_data_o),
    .strobe_o  (strobe_o),
    .err_o     (err_o)
);

// File: tb/tb_icr_file.sv
module tb_icr_file;
    localparam int          CLK_P   = 10;
    localparam logic [63:0] BASE_RV = 64'h0000_0000_0002_0000;
    localparam logic [63:0] ID_RV   = 64'h3;
    localparam int          SLOT    = 6;
    localparam logic [63:0] INTID_V = 64'h0000_0000_0000_0011;
    localparam logic [63:0] MMST_V  = 64'h0000_0000_0000_2222;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [5:0]  idx = '0;
    logic        we = 1'b0, re = 1'b0;
    logic [63:0] wd = '0;
    logic [31:0] cc = '0;
    logic [63:0] sum_set = '0, msk_set = '0;
    logic [63:0] rd_data;
    logic [4:0]  strobe;
    logic        err;

    int checks = 0;
    int errors = 0;

    logic [63:0] m [0:24];
    logic [63:0] exp_rd = '0;
    logic [4:0]  exp_stb = '0;
    logic        exp_err = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    icr_file #(.CODE_BASE_RST(BASE_RV), .CORE_ID(ID_RV), .ID_SLOT(SLOT)) dut (
        .clk(clk), .rst(rst), .idx_i(idx), .wr_en_i(we), .wr_data_i(wd),
        .rd_en_i(re), .cyc_cnt_i(cc), .exc_sum_set_i(sum_set),
        .exc_msk_set_i(msk_set), .int_id_i(INTID_V), .mm_stat_i(MMST_V),
        .rd_data_o(rd_data), .strobe_o(strobe), .err_o(err)
    );

    // 0 normal, 1 read-only, 2 write-only, 3 clear-on-write, 4 undefined
    function automatic int kind(input int i);
        if (i == 14 || i == 15) return 3;
        if (i <= 24) return 0;
        if (i == 25 || i == 26) return 1;
        if (i <= 31) return 2;
        return 4;
    endfunction

    function automatic logic [63:0] keep_bits(input int i);
        case (i)
            10, 11: return 64'hF;
            12, 13: return 64'h18;
            16:     return 64'hFF_FFFF_0300;
            17, 18: return 64'hFFFF_FFFF_C000_0000;
            19:     return 64'h1FFB;
            20, 21: return 64'h3F;
            22:     return 64'h7F0;
            23:     return 64'hFE00_0000_0000_0000;
            default: return 64'hFFFF_FFFF_FFFF_FFFF;
        endcase
    endfunction

    task automatic model_reset();
        for (int k = 0; k < 25; k++) m[k] = '0;
        m[8] = BASE_RV;
        m[9] = 64'h6;
        m[SLOT] = ID_RV;
        exp_rd = '0; exp_stb = '0; exp_err = 1'b0;
    endtask

    task automatic cmp(input string tag, input string what, input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s %s idx=%0d actual=%h expected=%h", tag, what, idx, act, expv);
        end
    endtask

    task automatic step(input logic w, input logic r, input int i, input logic [63:0] d, input string tag);
        int  kd;
        logic bad;
        @(negedge clk);
        we = w; re = r; idx = 6'(i); wd = d; cc = $urandom;
        kd  = kind(i);
        bad = (w && (kd == 1 || kd == 4)) || (r && (kd == 2 || kd == 4));
        exp_err = bad;
        exp_stb = '0;
        if (r) begin
            if (bad)           exp_rd = '0;
            else if (i == 24)  exp_rd = {m[24][63:32], cc};
            else if (i == 25)  exp_rd = INTID_V;
            else if (i == 26)  exp_rd = MMST_V;
            else               exp_rd = m[i];
        end
        if (w && !bad) begin
            if (kd == 2)      exp_stb = 5'(1 << (i - 27));
            else if (kd == 3) m[i] = '0;
            else              m[i] = d & keep_bits(i);
        end
        m[14] = m[14] | sum_set;
        m[15] = m[15] | msk_set;
        @(posedge clk);
        #1;
        cmp(tag, "rd_data", rd_data, exp_rd);
        cmp(tag, "err", {63'b0, err}, {63'b0, exp_err});
        cmp(tag, "strobe", {59'b0, strobe}, {59'b0, exp_stb});
    endtask

    initial begin
        #(CLK_P * 150000);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        cmp("R1", "reset rd_data", rd_data, 64'h0);
        cmp("R1", "reset err", {63'b0, err}, 64'h0);
        cmp("R1", "reset strobe", {59'b0, strobe}, 64'h0);

        // R1 reset contents, R7 read-only reads, R8 write-only reads refused
        for (int i = 0; i < 32; i++) step(1'b0, 1'b1, i, '0, "R1_R7_R8");

        // R2 R4 R5 R6 masks with all ones and a pattern
        for (int i = 0; i < 25; i++) begin
            step(1'b1, 1'b0, i, 64'hFFFF_FFFF_FFFF_FFFF, "R2_R4_R5");
            step(1'b0, 1'b1, i, '0, "R2_R4_R5");
        end
        for (int i = 0; i < 25; i++) begin
            step(1'b1, 1'b0, i, 64'h0123_4567_89AB_CDEF ^ 64'(i * 64'h1111), "R5");
            step(1'b0, 1'b1, i, '0, "R5");
        end

        // R3 composite cycle register
        step(1'b1, 1'b0, 24, 64'hDEAD_BEEF_1234_5678, "R3");
        step(1'b0, 1'b1, 24, '0, "R3");
        step(1'b0, 1'b1, 24, '0, "R3");

        // R6 event bits, clearing write, clear with concurrent event
        sum_set = 64'hF0; msk_set = 64'h5;
        step(1'b0, 1'b0, 0, '0, "R6");
        sum_set = '0; msk_set = '0;
        step(1'b0, 1'b1, 14, '0, "R6");
        step(1'b0, 1'b1, 15, '0, "R6");
        step(1'b1, 1'b0, 14, 64'hFFFF, "R6");
        step(1'b0, 1'b1, 14, '0, "R6");
        step(1'b0, 1'b1, 15, '0, "R6");
        sum_set = 64'h300;
        step(1'b1, 1'b0, 14, 64'h1, "R6");
        sum_set = '0;
        step(1'b0, 1'b1, 14, '0, "R6");

        // R7 R9 R10 illegal accesses leave contents unchanged
        step(1'b1, 1'b0, 25, 64'hAAAA, "R7_R10");
        step(1'b1, 1'b0, 26, 64'hBBBB, "R7_R10");
        step(1'b0, 1'b1, 25, '0, "R7");
        step(1'b1, 1'b0, 40, 64'h77, "R9_R10");
        step(1'b0, 1'b1, 63, '0, "R9_R10");
        step(1'b1, 1'b1, 32, 64'h9, "R9");
        // R10 combined access: illegal read blocks legal write
        step(1'b1, 1'b1, 27, 64'h1, "R10_R11");
        step(1'b1, 1'b0, 3, 64'h5555, "R10");
        step(1'b0, 1'b1, 3, '0, "R10");
        // R12 read and write same index returns old value
        step(1'b1, 1'b1, 3, 64'h6666, "R12");
        step(1'b0, 1'b1, 3, '0, "R12");
        step(1'b0, 1'b0, 3, '0, "R12");
        step(1'b0, 1'b0, 5, '0, "R12");

        // R11 strobes for each write-only index, no storage
        for (int i = 27; i < 32; i++) begin
            step(1'b1, 1'b0, i, 64'hFFFF, "R11");
            step(1'b0, 1'b0, i, '0, "R11");
        end

        // Random mix
        for (int n = 0; n < 600; n++) begin
            sum_set = ($urandom % 4 == 0) ? 64'($urandom) : '0;
            msk_set = ($urandom % 4 == 0) ? 64'($urandom) : '0;
            step(1'($urandom), 1'($urandom), int'($urandom % 64),
                 {32'($urandom), 32'($urandom)}, "R10_R12");
        end
        sum_set = '0; msk_set = '0;
        step(1'b0, 1'b0, 0, '0, "R12");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule